// File: doc/BRIEF.md
# Weighted Rising-Transition Energy Counter

This block estimates dynamic switching energy by watching a vector of logic signals. Once per clock it samples the probe vector and compares it with the sample from the previous clock. Every bit that went from low to high contributes its own fanout weight, which is set by a per-bit parameter. The sum of those weights is added to a wide accumulator in the same cycle. Falling edges and steady levels cost nothing. A pulse that rises and falls again between two clock edges is never seen.

The accumulator clamps at its largest value instead of wrapping around. A sticky flag records that the clamp happened. A synchronous clear empties the count and the flag. While the enable input is low the block keeps tracking the probe levels, but it adds nothing to the count.

Top module: `energy_meter`

## Requirements
- R1: A probe bit sampled high at a clock edge, after being sampled low at the previous edge, adds its parameter weight (`FANOUT_WEIGHTS` lane i, bits i*WEIGHT_W upward) to `energy`. The new value is visible after that edge.
- R2: A probe bit that goes from high to low adds nothing.
- R3: A probe bit that stays at the same level, low or high, adds nothing.
- R4: Every lane weight defaults to 1, so with default parameters each rising bit adds exactly 1.
- R5: When several bits rise at the same edge, the sum of all their weights is added at that single edge.
- R6: A `clear` of 1 at an edge sets `energy` to 0 and `overflow` to 0. Clear wins over any addition requested in the same cycle.
- R7: With `enable` at 0 nothing is added, but the previous-sample state still follows the probe. A rise that happens while disabled is therefore never counted later.
- R8: If an addition would exceed 2^ACC_W-1, `energy` takes the value 2^ACC_W-1 and `overflow` is set. `overflow` then stays at 1 until a clear or a reset.
- R9: A synchronous active-low reset gives `energy` 0 and `overflow` 0. Probe levels present during reset count as the previous sample and are not counted as rises.
- R10: A probe pulse that rises and falls back between two clock edges adds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Synchronous clear of count and flag |
| enable | input | 1 | Accumulation enable |
| probe | input | NUM_PROBES | Monitored signals |
| energy | output | ACC_W | Accumulated weighted rise count |
| overflow | output | 1 | Sticky saturation flag |

## Verification
Clearing and saturation can fall in the same cycle. In that case a clear must win over an addition that would push the count past its maximum. The bench first drives the counter into saturation with a long run of random probe patterns and no clears. It then applies a clear together with an all-bits rise and expects a count of zero and a low flag. The random phase that follows lets clears, disabled cycles and saturating additions collide freely. Every cycle is compared against a weighted reference model kept in the bench.

// File: rtl/energy_pkg.sv
// Shared sizing helpers for the energy meter.
// Assumes lane counts and weight widths are positive.
package energy_pkg;

    // Width needed to hold the sum of all lane weights without loss.
    function automatic int sum_width(input int lanes, input int wbits);
        return wbits + $clog2(lanes + 1);
    endfunction

endpackage

// File: rtl/rise_detect.sv
// Keeps the previous probe sample and flags bits that went low to high.
// Assumes probe is synchronous to clk. The sample register follows the
// probe in every cycle, reset included, so levels held through reset are
// never reported as rises.
module rise_detect #(
    parameter int NUM_PROBES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PROBES-1:0] probe,
    output logic [NUM_PROBES-1:0] rise
);

    logic [NUM_PROBES-1:0] prev_q;

    // Track the last sampled level; reset loads the live probe as well.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= probe;
        else        prev_q <= probe;
    end

    // A bit rose if it is high now and was low at the last edge.
    assign rise = probe & ~prev_q;

endmodule

// File: rtl/weight_sum.sv
// Turns a vector of rise flags into the total of their fanout weights.
// Assumes SUM_W is wide enough for the sum of all lane weights.
module weight_sum #(
    parameter int NUM_PROBES = 8,
    parameter int WEIGHT_W   = 4,
    parameter int SUM_W      = 8,
    parameter logic [NUM_PROBES*WEIGHT_W-1:0] WEIGHTS = '0
) (
    input  logic [NUM_PROBES-1:0] rise,
    output logic [SUM_W-1:0]      delta
);

    logic [WEIGHT_W-1:0] lane [NUM_PROBES];

    // Gate each lane weight by its rise flag.
    for (genvar g = 0; g < NUM_PROBES; g++) begin : g_lane
        assign lane[g] = rise[g] ? WEIGHTS[g*WEIGHT_W +: WEIGHT_W] : '0;
    end

    // Add the gated weights of all lanes.
    always_comb begin
        delta = '0;
        for (int i = 0; i < NUM_PROBES; i++) begin
            delta = delta + {{(SUM_W-WEIGHT_W){1'b0}}, lane[i]};
        end
    end

endmodule

// File: rtl/sat_accum.sv
// Saturating accumulator with a sticky overflow flag.
// Assumes ACC_W > SUM_W. Clear has priority over accumulation, and
// enable low freezes the count.
module sat_accum #(
    parameter int ACC_W = 16,
    parameter int SUM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic [SUM_W-1:0] delta,
    output logic [ACC_W-1:0] energy,
    output logic             overflow
);

    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    logic [ACC_W:0] trial;

    // Add with one spare bit so that a carry out shows a clamp.
    assign trial = {1'b0, energy} + {{(ACC_W+1-SUM_W){1'b0}}, delta};

    // Update the count and the flag: reset or clear first, then add or clamp.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            energy   <= '0;
            overflow <= 1'b0;
        end else if (enable) begin
            if (trial[ACC_W]) begin
                energy   <= ACC_MAX;
                overflow <= 1'b1;
            end else begin
                energy <= trial[ACC_W-1:0];
            end
        end
    end

    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (energy == '0) && !overflow);

    a_r7_disabled_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !clear) |=> $stable(energy) && $stable(overflow));

    a_r8_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clear) |=> overflow);

    a_r8_flag_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (energy == ACC_MAX));

    a_r1_never_decreases: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> energy >= $past(energy));

endmodule

// File: rtl/energy_meter.sv
// Top level: weighted count of zero-to-one transitions on a probe vector.
// Assumes every probe bit is synchronous to clk. Each lane's weight is
// taken from FANOUT_WEIGHTS, WEIGHT_W bits per lane, lane 0 in the low bits.
module energy_meter #(
    parameter int NUM_PROBES = 8,
    parameter int WEIGHT_W   = 4,
    parameter int ACC_W      = 16,
    parameter logic [NUM_PROBES*WEIGHT_W-1:0] FANOUT_WEIGHTS =
        {NUM_PROBES{{(WEIGHT_W-1){1'b0}}, 1'b1}}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  enable,
    input  logic [NUM_PROBES-1:0] probe,
    output logic [ACC_W-1:0]      energy,
    output logic                  overflow
);

    localparam int SUM_W = energy_pkg::sum_width(NUM_PROBES, WEIGHT_W);

    logic [NUM_PROBES-1:0] rise;
    logic [SUM_W-1:0]      delta;

    rise_detect #(.NUM_PROBES(NUM_PROBES)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .probe (probe),
        .rise  (rise)
    );

    weight_sum #(
        .NUM_PROBES (NUM_PROBES),
        .WEIGHT_W   (WEIGHT_W),
        .SUM_W      (SUM_W),
        .WEIGHTS    (FANOUT_WEIGHTS)
    ) u_sum (
        .rise  (rise),
        .delta (delta)
    );

    sat_accum #(.ACC_W(ACC_W), .SUM_W(SUM_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .enable   (enable),
        .delta    (delta),
        .energy   (energy),
        .overflow (overflow)
    );

    // No detected rise and no clear: the count must not move (R2, R3, R10).
    a_r3_no_rise_no_gain: assert property (@(posedge clk) disable iff (!rst_n)
        (rise == '0 && !clear) |=> $stable(energy));

endmodule

// File: tb/energy_meter_test.sv
module energy_meter_test;

    localparam int N   = 8;
    localparam int WW  = 4;
    localparam int AW  = 12;
    localparam int MAXV = (1 << AW) - 1;
    localparam logic [N*WW-1:0] WTS =
        {4'd8, 4'd7, 4'd6, 4'd5, 4'd4, 4'd3, 4'd2, 4'd1};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clear = 1'b0;
    logic         enable = 1'b1;
    logic [N-1:0] probe = '1;
    logic [AW-1:0] energy;
    logic          overflow;
    logic [15:0]   energy_def;
    logic          overflow_def;

    int total = 0;
    int failed = 0;
    bit done = 0;

    logic [N-1:0] m_prev;
    int m_acc, m_def;
    bit m_ovf;

    always #4 clk = ~clk;

    energy_meter #(.NUM_PROBES(N), .WEIGHT_W(WW), .ACC_W(AW),
                   .FANOUT_WEIGHTS(WTS)) uut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .enable(enable),
        .probe(probe), .energy(energy), .overflow(overflow));

    energy_meter dflt (
        .clk(clk), .rst_n(rst_n), .clear(clear), .enable(enable),
        .probe(probe), .energy(energy_def), .overflow(overflow_def));

    // Bit i carries weight i+1 in the bench's weighted instance.
    function automatic int wsum(input logic [N-1:0] r);
        int s = 0;
        for (int i = 0; i < N; i++) if (r[i]) s += i + 1;
        return s;
    endfunction

    task automatic compare(input string tag);
        total++;
        if (energy !== AW'(m_acc) || overflow !== m_ovf) begin
            failed++;
            $display("FAIL %s: energy=%0d ovf=%0b expected energy=%0d ovf=%0b",
                     tag, energy, overflow, m_acc, m_ovf);
        end
        total++;
        if (energy_def !== 16'(m_def)) begin
            failed++;
            $display("FAIL R4: default energy=%0d expected %0d", energy_def, m_def);
        end
    endtask

    // Apply one cycle of stimulus at a falling edge, then judge at the next one.
    task automatic step(input logic [N-1:0] p, input bit en, input bit clr,
                        input string tag_in);
        logic [N-1:0] r;
        int d;
        string tag;
        r = p & ~m_prev;
        d = wsum(r);
        if (tag_in != "")                  tag = tag_in;
        else if (clr)                      tag = "R6";
        else if (en && m_acc + d > MAXV)   tag = "R8";
        else if (!en)                      tag = "R7";
        else if ($countones(r) > 1)        tag = "R5";
        else if (r != '0)                  tag = "R1";
        else                               tag = "R3";
        probe = p; enable = en; clear = clr;
        if (clr) begin
            m_acc = 0; m_ovf = 0; m_def = 0;
        end else if (en) begin
            if (m_acc + d > MAXV) begin m_acc = MAXV; m_ovf = 1; end
            else m_acc += d;
            m_def += $countones(r);
        end
        m_prev = p;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failed++; total++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_acc = 0; m_def = 0; m_ovf = 0;
        repeat (3) @(negedge clk);
        compare("R9");                       // reset state
        m_prev = '1;
        rst_n = 1'b1;
        step(8'hFF, 1, 0, "R9");             // level held through reset: no rise
        step(8'h00, 1, 0, "R2");             // all bits fall
        step(8'h00, 1, 0, "R3");             // hold low
        step(8'h01, 1, 0, "R1");             // bit 0 rises: +1
        step(8'h01, 1, 0, "R3");             // hold high
        step(8'h0F, 1, 0, "R5");             // bits 1..3 rise: +9
        step(8'h8F, 0, 0, "R7");             // bit 7 rises while disabled
        step(8'h8F, 1, 0, "R7");             // not counted later
        step(8'h40, 1, 0, "R1");             // bit 6 rises: +7
        probe = ~m_prev;                     // pulse between two edges
        #2;
        step(m_prev, 1, 0, "R10");
        step(8'h00, 1, 0, "R2");
        step(8'hFF, 1, 1, "R6");             // clear beats the rises
        // Long run without clears to reach saturation.
        for (int k = 0; k < 700; k++)
            step(N'($urandom), 1'b1, 1'b0, "");
        if (!m_ovf) begin
            failed++; total++;
            $display("FAIL R8: saturation not reached, ovf=0 expected 1");
        end
        step(8'h00, 1, 0, "R8");
        step(8'hFF, 1, 1, "R6");             // clear and clamp together
        // Mixed random phase.
        for (int k = 0; k < 1500; k++)
            step(N'($urandom), ($urandom % 8) != 0, ($urandom % 150) == 0, "");
        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule